// File: doc/BRIEF.md
# Two-Stage Cascaded One-Hot Address Decoder

This block turns a 5-bit address into a 32-line one-hot select vector. It does not use one flat plane of AND terms. It is a small tree of decoder cells, and every cell has an enable input. A root cell decodes the two most significant address bits into four group enables. Each group enable drives one of four leaf cells. The leaf cells all receive the three least significant address bits in parallel, and each leaf produces eight select lines.

A single block enable goes only to the root cell. When it is low, no group is enabled and every select line sits at its inactive level.

A parameter sets the output sense. The lines can be active-high, or active-low so that the whole vector is inverted. The logic is purely combinational. A typical use is picking one of 32 targets, such as memory banks or actuator latches, from a binary address.

Top module: `casc_addr_decoder`

## Requirements
- R1: With the enable high, select line number 8*g + k is the active one, where g is the value of address bits [4:3] and k is the value of address bits [2:0].
- R2: With the enable high, exactly one of the 32 select lines is at its active level for every one of the 32 addresses.
- R3: With the enable low, all 32 select lines are at the inactive level for every address.
- R4: The eight lines of any leaf group other than the one named by address bits [4:3] are all at the inactive level.
- R5: Address 5'b01111 activates line 15 only, which is local line 7 of group 1.
- R6: Address 5'b11011 (decimal 27) activates line 27 only, which is local line 3 of group 3. Groups 0, 1 and 2 show all-inactive lines.
- R7: When the polarity parameter is set to active-low, the select vector is the bitwise inverse of the active-high vector. The active level is 0 and the inactive level is 1.
- R8: The select vector follows a change of address or enable without any clock, in the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Block enable, applied only to the root decoder cell |
| addr | input | 5 | Binary address; bits [4:3] choose the group, bits [2:0] the line within it |
| line_sel | output | 32 | One-hot select lines in the sense set by the polarity parameter |

## Verification
All 32 addresses are swept with the enable high. This separates a wrong group choice from a wrong line choice within a group, because every line must be hit exactly once at index 8*g + k.

The same sweep is repeated with the enable low. It shows that the gating reaches every leaf and not only the selected one.

Two fixed addresses, 01111 and 11011, land on the last line of an inner group and on a middle line of the top group. Both are checked slice by slice for the idle groups.

A second instance built with active-low outputs is swept as well. It must show the exact inverse, which separates a polarity fault from a decode fault.

// File: rtl/casc_dec_pkg.sv
package casc_dec_pkg;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } polarity_e;

    // Flat line index of local line k inside group g for groups of 2**lo_w lines
    function automatic int unsigned flat_index(int unsigned g, int unsigned k, int unsigned lo_w);
        return (g << lo_w) + k;
    endfunction

endpackage

// File: rtl/casc_dec_cell.sv
module casc_dec_cell #(
    parameter int SEL_W = 2
) (
    input  logic                    en,
    input  logic [SEL_W-1:0]        sel,
    output logic [(1<<SEL_W)-1:0]   hot
);
    localparam int N_OUT = 1 << SEL_W;

    for (genvar i = 0; i < N_OUT; i++) begin : g_term
        assign hot[i] = en & (sel == SEL_W'(i));
    end

    always_comb begin
        if (!$isunknown({en, sel})) begin
            // R3 / R4: a disabled cell keeps every line inactive
            a_r3_cell_idle: assert (en || hot == '0)
                else $error("disabled cell drives an active line");
            // R2: an enabled cell raises exactly one line
            a_r2_cell_onehot: assert (!en || $countones(hot) == 1)
                else $error("enabled cell not one-hot");
        end
    end

endmodule

// File: rtl/casc_dec_polarity.sv
module casc_dec_polarity
    import casc_dec_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter polarity_e POLARITY = POL_HIGH
) (
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] drv
);
    if (POLARITY == POL_LOW) begin : g_low
        assign drv = ~raw;
    end else begin : g_high
        assign drv = raw;
    end

    always_comb begin
        if (!$isunknown(raw)) begin
            // R7: in active-low mode the active count of the inverted sense matches the raw one
            a_r7_sense: assert ($countones(POLARITY == POL_LOW ? ~drv : drv) == $countones(raw))
                else $error("polarity stage changed the active count");
        end
    end

endmodule

// File: rtl/casc_addr_decoder.sv
module casc_addr_decoder
    import casc_dec_pkg::*;
#(
    parameter int        HI_W     = 2,
    parameter int        LO_W     = 3,
    parameter polarity_e POLARITY = POL_HIGH
) (
    input  logic                              en,
    input  logic [HI_W+LO_W-1:0]              addr,
    output logic [(1<<(HI_W+LO_W))-1:0]       line_sel
);
    localparam int ADDR_W = HI_W + LO_W;
    localparam int GROUPS = 1 << HI_W;
    localparam int LANES  = 1 << LO_W;
    localparam int OUT_N  = GROUPS * LANES;

    logic [HI_W-1:0]   grp_addr;
    logic [LO_W-1:0]   lane_addr;
    logic [GROUPS-1:0] grp_en;
    logic [OUT_N-1:0]  raw_sel;

    assign grp_addr  = addr[ADDR_W-1:LO_W];
    assign lane_addr = addr[LO_W-1:0];

    // Root stage: upper address bits pick one group; block enable enters only here
    casc_dec_cell #(.SEL_W(HI_W)) u_root (
        .en  (en),
        .sel (grp_addr),
        .hot (grp_en)
    );

    // Leaf stage: one cell per group, all sharing the lower address bits
    for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
        casc_dec_cell #(.SEL_W(LO_W)) u_leaf (
            .en  (grp_en[g]),
            .sel (lane_addr),
            .hot (raw_sel[g*LANES +: LANES])
        );
    end

    casc_dec_polarity #(.WIDTH(OUT_N), .POLARITY(POLARITY)) u_pol (
        .raw (raw_sel),
        .drv (line_sel)
    );

    always_comb begin
        if (!$isunknown({en, addr})) begin
            // R1: the active line sits at 8*g + k
            a_r1_index: assert (!en || raw_sel[flat_index(int'(grp_addr), int'(lane_addr), LO_W)])
                else $error("active line at wrong index");
            // R2: whole tree is one-hot when enabled
            a_r2_tree_onehot: assert (!en || $countones(raw_sel) == 1)
                else $error("tree output not one-hot");
            // R3: disabled block shows no active line
            a_r3_tree_idle: assert (en || raw_sel == '0)
                else $error("disabled block drives a line");
            // R4: root stage enables at most one leaf
            a_r4_one_leaf: assert ($onehot0(grp_en))
                else $error("more than one leaf enabled");
        end
    end

endmodule

// File: tb/tb_casc_addr_decoder.sv
module tb_casc_addr_decoder;
    import casc_dec_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        en  = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] sel_h;
    logic [31:0] sel_l;
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_addr_decoder #(.HI_W(2), .LO_W(3), .POLARITY(POL_HIGH)) dut (
        .en(en), .addr(addr), .line_sel(sel_h)
    );
    casc_addr_decoder #(.HI_W(2), .LO_W(3), .POLARITY(POL_LOW)) dut_n (
        .en(en), .addr(addr), .line_sel(sel_l)
    );

    function automatic logic [31:0] ref_vec(logic e, logic [4:0] a);
        return e ? (32'h1 << a) : 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s en=%0b addr=%0d actual=%h expected=%h", req, en, addr, act, exp);
        end
    endtask

    task automatic apply(logic e, logic [4:0] a);
        @(negedge clk);
        en   = e;
        addr = a;
        #1;
    endtask

    task automatic t_reset_state;
        apply(1'b0, 5'd0);
        check("R3 idle start", sel_h, 32'h0);
        check("R7 idle start low", sel_l, 32'hFFFF_FFFF);
    endtask

    task automatic t_sweep_enabled;
        for (int a = 0; a < 32; a++) begin
            apply(1'b1, 5'(a));
            check("R1 R2 sweep", sel_h, ref_vec(1'b1, 5'(a)));
            for (int g = 0; g < 4; g++)
                if (g != a / 8) check("R4 idle group", {24'h0, sel_h[g*8 +: 8]}, 32'h0);
        end
    endtask

    task automatic t_sweep_disabled;
        for (int a = 0; a < 32; a++) begin
            apply(1'b0, 5'(a));
            check("R3 disabled", sel_h, 32'h0);
        end
    endtask

    task automatic t_point_15;
        apply(1'b1, 5'b01111);
        check("R5 line 15", sel_h, 32'h0000_8000);
        check("R5 group 1 local 7", {24'h0, sel_h[15:8]}, 32'h80);
    endtask

    task automatic t_point_27;
        apply(1'b1, 5'b11011);
        check("R6 line 27", sel_h, 32'h0800_0000);
        check("R6 groups 0..2 idle", {8'h0, sel_h[23:0]}, 32'h0);
        check("R6 group 3 local 3", {24'h0, sel_h[31:24]}, 32'h08);
    endtask

    task automatic t_polarity;
        for (int e = 0; e < 2; e++)
            for (int a = 0; a < 32; a++) begin
                apply(1'(e), 5'(a));
                check("R7 active-low", sel_l, ~ref_vec(1'(e), 5'(a)));
            end
    endtask

    task automatic t_no_clock;
        // R8: change inputs mid-phase, away from any edge
        @(posedge clk);
        #2;
        en = 1'b1; addr = 5'd9;
        #1;
        check("R8 comb update", sel_h, 32'h0000_0200);
        addr = 5'd30;
        #1;
        check("R8 comb update", sel_h, 32'h4000_0000);
        en = 1'b0;
        #1;
        check("R8 comb disable", sel_h, 32'h0);
    endtask

    initial begin
        t_reset_state();
        t_sweep_enabled();
        t_sweep_disabled();
        t_point_15();
        t_point_27();
        t_polarity();
        t_no_clock();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule